// File: doc/BRIEF.md
# Loopback and Transmit Override Control

This block holds an 8-bit diagnostic register that shares a single write address with a general control register. A select latch decides which of the two registers a write lands in. The diagnostic register then steers two beat streams, one from the system side and one from the line receiver, to two destinations: the line transmitter and the system output. Its loop field picks one of four routings: no loop, near-end, digital or remote.

Each beat carries a data word and a two-bit kind tag: 00 is payload, 01 is an echo beat and 10 is the framing beat. Code 11 is handled as payload. Every beat built by the transmit path passes through an override stage, whichever port it leaves by. That stage can force the beat to all ones, clear echo beats, or drop the violation marker on the framing beat. The register also drives the slave-clock flag and the hold-sync flag as plain outputs.

Every stream interface is valid/ready. A beat moves when valid and ready are both high on the same rising edge. The routing is combinational: a source's ready is the ready of the destination it is routed to. An input that the selected mode does not use is drained, with ready held high and its beats discarded. An output that the mode does not use keeps valid low.

Top module: `loopback_ctl`

## Requirements
- R1: After reset the diagnostic register, the control register and the select latch are all zero. This gives loop mode 00, no overrides, and both flags low.
- R2: A write with the select latch at 0 loads the control register, and a write with the latch at 1 loads the diagnostic register. Bit 0 of every write updates the latch, so writing a diagnostic value with bit 0 clear returns later writes to the control register.
- R3: Loop field (bits 7:6) = 00 routes the system input through the override stage to the line transmit port. The line receive port goes unchanged to the system output.
- R4: Loop field = 01 (near end) sends the system input, after the override stage, to the system output. Line transmit valid stays low, and line receive beats are drained.
- R5: Loop field = 10 (digital) passes the system input unchanged to the system output, bypassing the overrides. Line transmit valid stays low, and line receive beats are drained.
- R6: Loop field = 11 (remote) sends the line receive stream through the override stage to the line transmit port. System output valid stays low, and system input beats are drained.
- R7: Bit 3 forces every transmit-path beat to all ones with no violation marker, in every loop mode. It takes priority over the echo and framing controls.
- R8: Bit 2 forces the data of echo beats (kind 01) on the transmit path to zero. Beats of other kinds are left unchanged.
- R9: A framing beat (kind 10) on line transmit has the violation marker set while bit 4 is 0, and clear while bit 4 is 1. Beats of other kinds never carry the marker.
- R10: The slave-mode output follows bit 1 and the hold-sync output follows bit 5 of the diagnostic register. Both change only on a diagnostic write.
- R11: In each mode, a routed source's ready equals its destination's ready, a drained input's ready is 1, and an unused output's valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the shared address |
| wr_data | input | 8 | Write data |
| sys_in_valid | input | 1 | System input beat valid |
| sys_in_ready | output | 1 | System input ready |
| sys_in_data | input | DW | System input data |
| sys_in_kind | input | 2 | System input kind tag |
| line_rx_valid | input | 1 | Line receive beat valid |
| line_rx_ready | output | 1 | Line receive ready |
| line_rx_data | input | DW | Line receive data |
| line_rx_kind | input | 2 | Line receive kind tag |
| line_tx_valid | output | 1 | Line transmit beat valid |
| line_tx_ready | input | 1 | Line transmit ready |
| line_tx_data | output | DW | Line transmit data |
| line_tx_kind | output | 2 | Line transmit kind tag |
| line_tx_viol | output | 1 | Violation marker for the framing beat |
| sys_out_valid | output | 1 | System output beat valid |
| sys_out_ready | input | 1 | System output ready |
| sys_out_data | output | DW | System output data |
| sys_out_kind | output | 2 | System output kind tag |
| ctrl_reg | output | 8 | Control register contents |
| reg_sel | output | 1 | Select latch (1 = diagnostic register) |
| loop_mode | output | 2 | Current loop field |
| slave_mode | output | 1 | Slave clocking flag |
| hold_sync | output | 1 | Hold-sync flag |

## Verification
Because the steering is combinational, a wrong loop field or override bit shows at the stream ports in the same cycle as the write that set it. Valid on the wrong output, a ready that ignores its destination, or altered data all appear at once. A select latch that has gone wrong shows only one write later, when a value meant for one register changes the other. The bench therefore follows each write with a read of both `ctrl_reg` and the routing.

// File: rtl/loopback_pkg.sv
package loopback_pkg;
  typedef enum logic [1:0] {
    LOOP_NONE    = 2'b00,
    LOOP_NEAR    = 2'b01,
    LOOP_DIGITAL = 2'b10,
    LOOP_REMOTE  = 2'b11
  } loop_e;

  localparam logic [1:0] KIND_DATA  = 2'b00;
  localparam logic [1:0] KIND_ECHO  = 2'b01;
  localparam logic [1:0] KIND_FRAME = 2'b10;

  localparam int REG_W      = 8;
  localparam int BIT_SEL    = 0;
  localparam int BIT_SLAVE  = 1;
  localparam int BIT_ECHO0  = 2;
  localparam int BIT_IDLE   = 3;
  localparam int BIT_FNORM  = 4;
  localparam int BIT_HOLD   = 5;
  localparam int BIT_LOOPLO = 6;
endpackage

// File: rtl/diag_regs.sv
module diag_regs
  import loopback_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] diag_q,
  output logic [REG_W-1:0] ctrl_q,
  output logic             sel_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      diag_q <= '0;
      ctrl_q <= '0;
      sel_q  <= 1'b0;
    end else if (wr_en) begin
      if (sel_q) diag_q <= wr_data;
      else       ctrl_q <= wr_data;
      sel_q <= wr_data[BIT_SEL];
    end
  end
endmodule

// File: rtl/tx_override.sv
module tx_override
  import loopback_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] in_data,
  input  logic [1:0]    in_kind,
  input  logic          force_idle,
  input  logic          echo_zero,
  input  logic          frame_normal,
  output logic [DW-1:0] out_data,
  output logic          out_viol
);
  always_comb begin
    out_data = in_data;
    out_viol = 1'b0;
    if (force_idle) begin
      out_data = '1;
    end else begin
      if (echo_zero && in_kind == KIND_ECHO) out_data = '0;
      out_viol = (in_kind == KIND_FRAME) && !frame_normal;
    end
  end
endmodule

// File: rtl/loop_router.sv
module loop_router
  import loopback_pkg::*;
#(
  parameter int DW = 8
) (
  input  loop_e         mode,
  input  logic          sys_in_valid,
  output logic          sys_in_ready,
  input  logic [DW-1:0] sys_in_data,
  input  logic [1:0]    sys_in_kind,
  input  logic          line_rx_valid,
  output logic          line_rx_ready,
  input  logic [DW-1:0] line_rx_data,
  input  logic [1:0]    line_rx_kind,
  output logic [DW-1:0] src_data,
  output logic [1:0]    src_kind,
  input  logic [DW-1:0] ovr_data,
  output logic          line_tx_valid,
  input  logic          line_tx_ready,
  output logic          sys_out_valid,
  input  logic          sys_out_ready,
  output logic [DW-1:0] sys_out_data,
  output logic [1:0]    sys_out_kind
);
  always_comb begin
    sys_in_ready  = 1'b0;
    line_rx_ready = 1'b0;
    line_tx_valid = 1'b0;
    sys_out_valid = 1'b0;
    src_data      = sys_in_data;
    src_kind      = sys_in_kind;
    sys_out_data  = line_rx_data;
    sys_out_kind  = line_rx_kind;
    unique case (mode)
      LOOP_NONE: begin
        line_tx_valid = sys_in_valid;
        sys_in_ready  = line_tx_ready;
        sys_out_valid = line_rx_valid;
        line_rx_ready = sys_out_ready;
      end
      LOOP_NEAR: begin
        sys_out_valid = sys_in_valid;
        sys_out_data  = ovr_data;
        sys_out_kind  = sys_in_kind;
        sys_in_ready  = sys_out_ready;
        line_rx_ready = 1'b1;
      end
      LOOP_DIGITAL: begin
        sys_out_valid = sys_in_valid;
        sys_out_data  = sys_in_data;
        sys_out_kind  = sys_in_kind;
        sys_in_ready  = sys_out_ready;
        line_rx_ready = 1'b1;
      end
      LOOP_REMOTE: begin
        src_data      = line_rx_data;
        src_kind      = line_rx_kind;
        line_tx_valid = line_rx_valid;
        line_rx_ready = line_tx_ready;
        sys_in_ready  = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/loopback_ctl.sv
module loopback_ctl
  import loopback_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  input  logic          sys_in_valid,
  output logic          sys_in_ready,
  input  logic [DW-1:0] sys_in_data,
  input  logic [1:0]    sys_in_kind,
  input  logic          line_rx_valid,
  output logic          line_rx_ready,
  input  logic [DW-1:0] line_rx_data,
  input  logic [1:0]    line_rx_kind,
  output logic          line_tx_valid,
  input  logic          line_tx_ready,
  output logic [DW-1:0] line_tx_data,
  output logic [1:0]    line_tx_kind,
  output logic          line_tx_viol,
  output logic          sys_out_valid,
  input  logic          sys_out_ready,
  output logic [DW-1:0] sys_out_data,
  output logic [1:0]    sys_out_kind,
  output logic [7:0]    ctrl_reg,
  output logic          reg_sel,
  output logic [1:0]    loop_mode,
  output logic          slave_mode,
  output logic          hold_sync
);
  logic [REG_W-1:0] diag_q;
  logic [DW-1:0]    src_data;
  logic [1:0]       src_kind;
  logic [DW-1:0]    ovr_data;
  logic             ovr_viol;
  loop_e            mode;

  diag_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .diag_q  (diag_q),
    .ctrl_q  (ctrl_reg),
    .sel_q   (reg_sel)
  );

  assign mode       = loop_e'(diag_q[BIT_LOOPLO +: 2]);
  assign loop_mode  = diag_q[BIT_LOOPLO +: 2];
  assign slave_mode = diag_q[BIT_SLAVE];
  assign hold_sync  = diag_q[BIT_HOLD];

  tx_override #(.DW(DW)) u_ovr (
    .in_data      (src_data),
    .in_kind      (src_kind),
    .force_idle   (diag_q[BIT_IDLE]),
    .echo_zero    (diag_q[BIT_ECHO0]),
    .frame_normal (diag_q[BIT_FNORM]),
    .out_data     (ovr_data),
    .out_viol     (ovr_viol)
  );

  loop_router #(.DW(DW)) u_route (
    .mode          (mode),
    .sys_in_valid  (sys_in_valid),
    .sys_in_ready  (sys_in_ready),
    .sys_in_data   (sys_in_data),
    .sys_in_kind   (sys_in_kind),
    .line_rx_valid (line_rx_valid),
    .line_rx_ready (line_rx_ready),
    .line_rx_data  (line_rx_data),
    .line_rx_kind  (line_rx_kind),
    .src_data      (src_data),
    .src_kind      (src_kind),
    .ovr_data      (ovr_data),
    .line_tx_valid (line_tx_valid),
    .line_tx_ready (line_tx_ready),
    .sys_out_valid (sys_out_valid),
    .sys_out_ready (sys_out_ready),
    .sys_out_data  (sys_out_data),
    .sys_out_kind  (sys_out_kind)
  );

  assign line_tx_data = ovr_data;
  assign line_tx_kind = src_kind;
  assign line_tx_viol = ovr_viol;
endmodule

// File: rtl/loopback_ctl_chk.sv
module loopback_ctl_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [7:0]    wr_data,
  input logic          reg_sel,
  input logic [7:0]    ctrl_reg,
  input logic [1:0]    loop_mode,
  input logic          slave_mode,
  input logic          idle,
  input logic          sys_in_ready,
  input logic          line_tx_ready,
  input logic          line_tx_valid,
  input logic [DW-1:0] line_tx_data,
  input logic          line_tx_viol,
  input logic          sys_out_valid,
  input logic          line_rx_ready
);
  a_r2_ctrl_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !reg_sel) |=> (ctrl_reg == $past(wr_data)));
  a_r2_sel_update: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (reg_sel == $past(wr_data[0])));
  a_r2_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel) |=> $stable(ctrl_reg));
  a_r6_no_sys_out: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_mode == 2'b11) |-> !sys_out_valid);
  a_r4_no_line_tx: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_mode == 2'b01 || loop_mode == 2'b10) |-> (!line_tx_valid && line_rx_ready));
  a_r7_idle_ones: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (line_tx_data == {DW{1'b1}} && !line_tx_viol));
  a_r10_slave_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(slave_mode));
  a_r11_none_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_mode == 2'b00) |-> (sys_in_ready == line_tx_ready));
endmodule

bind loopback_ctl loopback_ctl_chk #(.DW(DW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .wr_en         (wr_en),
  .wr_data       (wr_data),
  .reg_sel       (reg_sel),
  .ctrl_reg      (ctrl_reg),
  .loop_mode     (loop_mode),
  .slave_mode    (slave_mode),
  .idle          (diag_q[3]),
  .sys_in_ready  (sys_in_ready),
  .line_tx_ready (line_tx_ready),
  .line_tx_valid (line_tx_valid),
  .line_tx_data  (line_tx_data),
  .line_tx_viol  (line_tx_viol),
  .sys_out_valid (sys_out_valid),
  .line_rx_ready (line_rx_ready)
);

// File: tb/test_loopback_ctl.sv
module test_loopback_ctl;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic sys_in_valid = 1'b0, line_rx_valid = 1'b0;
  logic line_tx_ready = 1'b0, sys_out_ready = 1'b0;
  logic [DW-1:0] sys_in_data = '0, line_rx_data = '0;
  logic [1:0] sys_in_kind = '0, line_rx_kind = '0;
  logic sys_in_ready, line_rx_ready, line_tx_valid, line_tx_viol, sys_out_valid;
  logic [DW-1:0] line_tx_data, sys_out_data;
  logic [1:0] line_tx_kind, sys_out_kind, loop_mode;
  logic [7:0] ctrl_reg;
  logic reg_sel, slave_mode, hold_sync;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  loopback_ctl #(.DW(DW)) i_loopback_ctl (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic set_diag(input logic [7:0] v);
    if (!reg_sel) wr(8'h01);
    wr(v);
    if (reg_sel) wr(8'h00);
  endtask

  task automatic drive(input logic [DW-1:0] sd, input logic [1:0] sk,
                       input logic [DW-1:0] rd, input logic [1:0] rk,
                       input logic txr, input logic sor);
    sys_in_valid = 1'b1; sys_in_data = sd; sys_in_kind = sk;
    line_rx_valid = 1'b1; line_rx_data = rd; line_rx_kind = rk;
    line_tx_ready = txr; sys_out_ready = sor;
    #1;
  endtask

  task automatic t_reset();
    check(ctrl_reg == 0, "R1 ctrl", ctrl_reg, 0);
    check(reg_sel == 0, "R1 sel", reg_sel, 0);
    check(loop_mode == 0 && !slave_mode && !hold_sync, "R1 diag",
          {loop_mode, slave_mode, hold_sync}, 0);
  endtask

  task automatic t_select();
    wr(8'h5A);
    check(ctrl_reg == 8'h5A && reg_sel == 0, "R2 ctrl write", {ctrl_reg, 7'd0, reg_sel}, 32'h5A00);
    wr(8'h01);
    check(reg_sel == 1 && ctrl_reg == 8'h01, "R2 latch set", {ctrl_reg, 7'd0, reg_sel}, 32'h0101);
    wr(8'hC5);
    check(loop_mode == 2'b11 && ctrl_reg == 8'h01 && reg_sel, "R2 diag write",
          {loop_mode, ctrl_reg, reg_sel}, {2'b11, 8'h01, 1'b1});
    wr(8'h00);
    check(loop_mode == 2'b00 && reg_sel == 0 && ctrl_reg == 8'h01, "R2 switch back",
          {loop_mode, ctrl_reg, reg_sel}, {2'b00, 8'h01, 1'b0});
    wr(8'h33);
    check(ctrl_reg == 8'h33 && loop_mode == 2'b00, "R2 ctrl again", ctrl_reg, 8'h33);
    wr(8'h00);
  endtask

  task automatic t_none();
    set_diag(8'h00);
    @(negedge clk); drive(8'h3C, 2'b00, 8'hA5, 2'b01, 1'b1, 1'b0);
    check(line_tx_valid && line_tx_data == 8'h3C && line_tx_kind == 0, "R3 tx", line_tx_data, 8'h3C);
    check(sys_out_valid && sys_out_data == 8'hA5 && sys_out_kind == 2'b01, "R3 rx", sys_out_data, 8'hA5);
    check(sys_in_ready == 1 && line_rx_ready == 0, "R11 none ready",
          {sys_in_ready, line_rx_ready}, 2'b10);
  endtask

  task automatic t_near();
    set_diag(8'h40);
    @(negedge clk); drive(8'h5E, 2'b00, 8'h11, 2'b00, 1'b1, 1'b1);
    check(sys_out_valid && sys_out_data == 8'h5E && !line_tx_valid, "R4 near",
          {sys_out_data, line_tx_valid}, {8'h5E, 1'b0});
    sys_out_ready = 1'b0; #1;
    check(!sys_in_ready && line_rx_ready, "R11 near ready", {sys_in_ready, line_rx_ready}, 2'b01);
  endtask

  task automatic t_digital();
    set_diag(8'h8C);
    @(negedge clk); drive(8'h00, 2'b01, 8'h22, 2'b00, 1'b1, 1'b1);
    check(sys_out_valid && sys_out_data == 8'h00 && sys_out_kind == 2'b01, "R5 digital bypass",
          sys_out_data, 8'h00);
    check(!line_tx_valid && line_rx_ready && sys_in_ready, "R5 digital ports",
          {line_tx_valid, line_rx_ready, sys_in_ready}, 3'b011);
  endtask

  task automatic t_remote();
    set_diag(8'hC0);
    @(negedge clk); drive(8'h99, 2'b00, 8'h6B, 2'b00, 1'b0, 1'b1);
    check(line_tx_valid && line_tx_data == 8'h6B && !sys_out_valid, "R6 remote",
          {line_tx_data, sys_out_valid}, {8'h6B, 1'b0});
    check(!line_rx_ready && sys_in_ready, "R11 remote ready", {line_rx_ready, sys_in_ready}, 2'b01);
  endtask

  task automatic t_idle();
    set_diag(8'hCC);
    @(negedge clk); drive(8'h00, 2'b00, 8'h00, 2'b10, 1'b1, 1'b1);
    check(line_tx_data == 8'hFF && !line_tx_viol, "R7 idle remote", {line_tx_data, line_tx_viol}, 9'h1FE);
    set_diag(8'h4C);
    @(negedge clk); drive(8'h12, 2'b01, 8'h00, 2'b00, 1'b1, 1'b1);
    check(sys_out_data == 8'hFF, "R7 idle near", sys_out_data, 8'hFF);
  endtask

  task automatic t_echo();
    set_diag(8'h04);
    @(negedge clk); drive(8'h7E, 2'b01, 8'h00, 2'b00, 1'b1, 1'b1);
    check(line_tx_data == 8'h00, "R8 echo zeroed", line_tx_data, 0);
    sys_in_kind = 2'b00; #1;
    check(line_tx_data == 8'h7E, "R8 data untouched", line_tx_data, 8'h7E);
  endtask

  task automatic t_frame();
    set_diag(8'h00);
    @(negedge clk); drive(8'h0F, 2'b10, 8'h00, 2'b00, 1'b1, 1'b1);
    check(line_tx_viol == 1 && line_tx_data == 8'h0F, "R9 violation", line_tx_viol, 1);
    sys_in_kind = 2'b01; #1;
    check(line_tx_viol == 0, "R9 echo no marker", line_tx_viol, 0);
    set_diag(8'h10);
    @(negedge clk); drive(8'h0F, 2'b10, 8'h00, 2'b00, 1'b1, 1'b1);
    check(line_tx_viol == 0, "R9 normal framing", line_tx_viol, 0);
  endtask

  task automatic t_flags();
    set_diag(8'h22);
    check(slave_mode && hold_sync, "R10 flags set", {slave_mode, hold_sync}, 2'b11);
    wr(8'h00);
    check(slave_mode && hold_sync, "R10 ctrl write keeps flags", {slave_mode, hold_sync}, 2'b11);
    set_diag(8'h02);
    check(slave_mode && !hold_sync, "R10 hold clear", {slave_mode, hold_sync}, 2'b10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_select();
    t_none();
    t_near();
    t_digital();
    t_remote();
    t_idle();
    t_echo();
    t_frame();
    t_flags();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule